// File: doc/BRIEF.md
# Vector Element Word Load Unit

This unit carries out one load of a single 32-bit word into one lane of a 128-bit vector register. It takes an instruction word and checks that it is the element-word-load encoding. It then adds two 64-bit general-purpose operands to form the effective address, with a literal zero replacing the first operand when that operand's register field is zero. The two lowest address bits are cleared, so every access is word aligned. A 4-byte read goes out on a valid/ready request port. When the response arrives, the word is written into the vector register file.

Address bits 3:2 pick the lane. In big-endian mode the word lands in lane `addr[3:2]`, counted from the most significant end. In little-endian mode the lane index is mirrored and the word's bytes are reversed. The bytes outside the written lane are always written as zero. When the vector facility is disabled, the instruction ends in a one-cycle exception pulse, with no memory read and no register write. One instruction is in flight at a time, and a busy flag covers it from acceptance to completion.

Top module: `vec_word_load_unit`

## Requirements
- R1: An instruction is accepted only if bits 31:26 equal 31 and bits 25:21, 20:16 and 15:11 are the target, first and second operand fields, and bits 10:1 equal 71. Any other word leaves busy, the read request and the write enable low.
- R2: The request address is the second operand plus either zero (first operand field equal to 0) or the first operand value (any other field value), computed modulo 2^64.
- R3: The request address has bits 1:0 cleared.
- R4: rd_req_valid rises on the cycle after acceptance and stays high, with rd_req_addr unchanged, until a cycle in which rd_req_ready is high.
- R5: In big-endian mode (little_end=0), with eb = address bits 3:0, memory byte i lands in target byte eb+i. Memory byte i is rd_rsp_data[31-8i -: 8], and byte 0 is the lowest address. Target byte k is vwr_data[127-8k -: 8].
- R6: In little-endian mode (little_end=1), memory byte i lands in target byte 15-eb-i.
- R7: Every vwr_data byte outside the written lane is zero during a write. vwr_data is all zero when vwr_en is low.
- R8: vwr_en is high for exactly one cycle, the cycle after the one in which rd_rsp_valid is seen following the request handshake. vwr_idx then equals the target field plus 32.
- R9: An accepted instruction with vec_en=0 gives a vec_unavail pulse of one cycle on the next cycle, with no read request and no write.
- R10: busy is high from the cycle after acceptance through the write or exception cycle. An instruction presented while busy is ignored.
- R11: During reset, busy, rd_req_valid, vwr_en and vec_unavail are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word present |
| insn | input | 32 | Instruction word |
| gpr_a | input | 64 | Value of the first operand register |
| gpr_b | input | 64 | Value of the second operand register |
| vec_en | input | 1 | Vector facility enabled |
| little_end | input | 1 | Little-endian byte ordering when high |
| busy | output | 1 | Instruction in flight |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 64 | Aligned read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read word, lowest address in bits 31:24 |
| vwr_en | output | 1 | Vector register write enable |
| vwr_idx | output | 6 | Vector register index |
| vwr_data | output | 128 | Vector register write data |
| vec_unavail | output | 1 | Vector-unavailable exception pulse |

## Verification
The request and the exception pulse are due one cycle after the edge that accepts the instruction. The write is due one cycle after the edge that samples rd_rsp_valid. The request handshake itself may last any number of cycles. The bench steps a behavioural model on the same edges as the design and compares every output a quarter period after each rising edge, so each result is checked in exactly the cycle it is due and not in any other. Ready and response delays vary between instructions, which covers both the held request and the data-to-write latency.

// File: rtl/vlw_pkg.sv
package vlw_pkg;

  localparam int INSN_W      = 32;
  localparam int FIELD_W     = 5;
  localparam logic [5:0] PRIMARY_OPCODE = 6'd31;
  localparam logic [9:0] EXTENDED_OPCODE = 10'd71;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_EXC
  } vlw_state_e;

endpackage

// File: rtl/vlw_rst_sync.sv
module vlw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/vlw_decode.sv
module vlw_decode
  import vlw_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int WORD      = 32,
  parameter int FIELD_BITS = FIELD_W
) (
  input  logic [INSN_W-1:0]     insn,
  input  logic [XLEN-1:0]       gpr_a,
  input  logic [XLEN-1:0]       gpr_b,
  output logic                  insn_match,
  output logic [FIELD_BITS-1:0] vrt,
  output logic [XLEN-1:0]       ea
);

  localparam int ALIGN_BITS = $clog2(WORD / 8);

  logic [5:0]            prim_op;
  logic [9:0]            ext_op;
  logic [FIELD_BITS-1:0] ra_field;
  logic [XLEN-1:0]       base;
  logic [XLEN-1:0]       sum;
  logic                  unused_reserved;

  assign prim_op  = insn[31:26];
  assign vrt      = insn[25:21];
  assign ra_field = insn[20:16];
  assign ext_op   = insn[10:1];
  assign unused_reserved = insn[0] ^ (^insn[15:11]);

  assign insn_match = (prim_op == PRIMARY_OPCODE) && (ext_op == EXTENDED_OPCODE);

  always_comb begin
    base = (ra_field == '0) ? '0 : gpr_a;
    sum  = base + gpr_b;
    ea   = {sum[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  end

endmodule

// File: rtl/vlw_lane_place.sv
module vlw_lane_place #(
  parameter int VLEN      = 128,
  parameter int WORD      = 32,
  parameter int LANE_BITS = $clog2(VLEN / WORD)
) (
  input  logic                 en,
  input  logic [WORD-1:0]      word,
  input  logic [LANE_BITS-1:0] lane,
  input  logic                 little_end,
  output logic [VLEN-1:0]      vec
);

  localparam int LANES  = VLEN / WORD;
  localparam int NBYTES = WORD / 8;

  logic [WORD-1:0]      swapped;
  logic [WORD-1:0]      lane_word;
  logic [LANE_BITS-1:0] sel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = word[WORD-8-8*b +: 8];
  end

  always_comb begin
    sel       = little_end ? (LANE_BITS'(LANES - 1) - lane) : lane;
    lane_word = little_end ? swapped : word;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign vec[VLEN-WORD*(l+1) +: WORD] =
      (en && (sel == LANE_BITS'(l))) ? lane_word : '0;
  end

endmodule

// File: rtl/vlw_ctrl.sv
module vlw_ctrl
  import vlw_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int WORD       = 32,
  parameter int FIELD_BITS = FIELD_W,
  parameter int IDX_BITS   = FIELD_BITS + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  insn_valid,
  input  logic                  insn_match,
  input  logic                  vec_en,
  input  logic                  little_end,
  input  logic [XLEN-1:0]       ea,
  input  logic [FIELD_BITS-1:0] vrt,
  input  logic                  rd_req_ready,
  input  logic                  rd_rsp_valid,
  input  logic [WORD-1:0]       rd_rsp_data,
  output logic                  busy,
  output logic                  rd_req_valid,
  output logic [XLEN-1:0]       rd_req_addr,
  output logic                  vwr_en,
  output logic [IDX_BITS-1:0]   vwr_idx,
  output logic                  vec_unavail,
  output logic [WORD-1:0]       word_q,
  output logic [XLEN-1:0]       addr_q,
  output logic                  le_q
);

  vlw_state_e            state_q, state_d;
  logic [FIELD_BITS-1:0] vrt_q;
  logic                  accept;
  logic                  ctx_en;
  logic                  data_en;

  assign accept  = (state_q == ST_IDLE) && insn_valid && insn_match;
  assign ctx_en  = accept && vec_en;
  assign data_en = (state_q == ST_WAIT) && rd_rsp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = vec_en ? ST_REQ : ST_EXC;
      ST_REQ:   if (rd_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (rd_rsp_valid) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      ST_EXC:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vrt_q  <= '0;
      le_q   <= 1'b0;
    end else if (ctx_en) begin
      addr_q <= ea;
      vrt_q  <= vrt;
      le_q   <= little_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (data_en) begin
      word_q <= rd_rsp_data;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_req_addr  = rd_req_valid ? addr_q : '0;
  assign vwr_en       = (state_q == ST_WRITE);
  assign vwr_idx      = vwr_en ? {1'b1, vrt_q} : '0;
  assign vec_unavail  = (state_q == ST_EXC);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R4

  AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) && rd_rsp_valid |=> vwr_en && !rd_req_valid); // R8

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vwr_en |=> !vwr_en); // R8

  AST_EXC_ON_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !vec_en |=> vec_unavail && !rd_req_valid && !vwr_en); // R9

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !vwr_en && !vec_unavail |=> busy); // R10

endmodule

// File: rtl/vec_word_load_unit.sv
module vec_word_load_unit
  import vlw_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int VLEN       = 128,
  parameter int WORD       = 32,
  parameter int IDX_BITS   = FIELD_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                insn_valid,
  input  logic [INSN_W-1:0]   insn,
  input  logic [XLEN-1:0]     gpr_a,
  input  logic [XLEN-1:0]     gpr_b,
  input  logic                vec_en,
  input  logic                little_end,
  output logic                busy,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [XLEN-1:0]     rd_req_addr,
  input  logic                rd_rsp_valid,
  input  logic [WORD-1:0]     rd_rsp_data,
  output logic                vwr_en,
  output logic [IDX_BITS-1:0] vwr_idx,
  output logic [VLEN-1:0]     vwr_data,
  output logic                vec_unavail
);

  localparam int ALIGN_BITS = $clog2(WORD / 8);
  localparam int LANE_BITS  = $clog2(VLEN / WORD);

  logic               rst_sync_n;
  logic               insn_match;
  logic [FIELD_W-1:0] vrt;
  logic [XLEN-1:0]    ea;
  logic [WORD-1:0]    word_q;
  logic [XLEN-1:0]    addr_q;
  logic               le_q;

  vlw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vlw_decode #(.XLEN(XLEN), .WORD(WORD), .FIELD_BITS(FIELD_W)) u_decode (
    .insn       (insn),
    .gpr_a      (gpr_a),
    .gpr_b      (gpr_b),
    .insn_match (insn_match),
    .vrt        (vrt),
    .ea         (ea)
  );

  vlw_ctrl #(.XLEN(XLEN), .WORD(WORD), .FIELD_BITS(FIELD_W), .IDX_BITS(IDX_BITS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .insn_valid   (insn_valid),
    .insn_match   (insn_match),
    .vec_en       (vec_en),
    .little_end   (little_end),
    .ea           (ea),
    .vrt          (vrt),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .busy         (busy),
    .rd_req_valid (rd_req_valid),
    .rd_req_addr  (rd_req_addr),
    .vwr_en       (vwr_en),
    .vwr_idx      (vwr_idx),
    .vec_unavail  (vec_unavail),
    .word_q       (word_q),
    .addr_q       (addr_q),
    .le_q         (le_q)
  );

  vlw_lane_place #(.VLEN(VLEN), .WORD(WORD), .LANE_BITS(LANE_BITS)) u_place (
    .en         (vwr_en),
    .word       (word_q),
    .lane       (addr_q[ALIGN_BITS +: LANE_BITS]),
    .little_end (le_q),
    .vec        (vwr_data)
  );

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_req_valid |-> (rd_req_addr[ALIGN_BITS-1:0] == '0)); // R3

  AST_NO_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !vwr_en |-> (vwr_data == '0)); // R7

endmodule

// File: tb/tb_vec_word_load_unit.sv
module tb_vec_word_load_unit;

  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         insn_valid;
  logic [31:0]  insn;
  logic [63:0]  gpr_a, gpr_b;
  logic         vec_en, little_end;
  logic         busy, rd_req_valid, rd_req_ready;
  logic [63:0]  rd_req_addr;
  logic         rd_rsp_valid;
  logic [31:0]  rd_rsp_data;
  logic         vwr_en;
  logic [5:0]   vwr_idx;
  logic [127:0] vwr_data;
  logic         vec_unavail;

  vec_word_load_unit dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .gpr_a(gpr_a), .gpr_b(gpr_b), .vec_en(vec_en), .little_end(little_end),
    .busy(busy), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .vwr_en(vwr_en), .vwr_idx(vwr_idx), .vwr_data(vwr_data), .vec_unavail(vec_unavail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 1'b0;
  bit done     = 1'b0;

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(int vrt, int ra, int rb);
    return {6'd31, 5'(vrt), 5'(ra), 5'(rb), 10'd71, 1'b0};
  endfunction

  function automatic logic [127:0] place(logic [31:0] d, logic [63:0] a, bit le, bit mask_only);
    logic [127:0] v = '0;
    int eb = int'(a[3:0]);
    for (int i = 0; i < 4; i++) begin
      int t = le ? (15 - eb - i) : (eb + i);
      v[127-8*t -: 8] = mask_only ? 8'hFF : d[31-8*i -: 8];
    end
    return v;
  endfunction

  // Reference model: 0 idle, 1 request, 2 wait, 3 write, 4 exception
  int          m_st;
  logic [63:0] m_addr;
  logic [4:0]  m_vrt;
  bit          m_le;
  logic [31:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0;
    end else begin
      case (m_st)
        0: if (insn_valid && insn[31:26] == 6'd31 && insn[10:1] == 10'd71) begin
             if (vec_en) begin
               logic [63:0] s;
               s = ((insn[20:16] == 5'd0) ? 64'd0 : gpr_a) + gpr_b;
               m_addr <= s & ~64'd3;
               m_vrt  <= insn[25:21];
               m_le   <= little_end;
               m_st   <= 1;
             end else begin
               m_st <= 4;
             end
           end
        1: if (rd_req_ready) m_st <= 2;
        2: if (rd_rsp_valid) begin m_data <= rd_rsp_data; m_st <= 3; end
        default: m_st <= 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (cmp_on) begin
      chk("R10", "busy", 128'(busy), 128'(m_st != 0));
      chk("R4", "rd_req_valid", 128'(rd_req_valid), 128'(m_st == 1));
      if (m_st == 1) begin
        chk("R2", "rd_req_addr", 128'(rd_req_addr), 128'(m_addr));
        chk("R3", "addr low bits", 128'(rd_req_addr[1:0]), 128'(0));
      end
      chk("R8", "vwr_en", 128'(vwr_en), 128'(m_st == 3));
      chk("R9", "vec_unavail", 128'(vec_unavail), 128'(m_st == 4));
      if (m_st == 3) begin
        chk("R8", "vwr_idx", 128'(vwr_idx), 128'(6'(m_vrt) + 6'd32));
        chk(m_le ? "R6" : "R5", "vwr_data", vwr_data, place(m_data, m_addr, m_le, 1'b0));
        chk("R7", "bytes outside lane", vwr_data & ~place(m_data, m_addr, m_le, 1'b1), '0);
      end else begin
        chk("R7", "idle vwr_data", vwr_data, '0);
      end
    end
  end

  // Memory responder
  bit pend = 1'b0;
  int dly  = 0;

  always @(posedge clk) begin
    if (rd_req_valid && rd_req_ready) begin
      pend <= 1'b1;
      dly  <= $urandom_range(0, 3);
    end else if (rd_rsp_valid) begin
      pend <= 1'b0;
    end
  end

  always @(negedge clk) begin
    rd_req_ready <= ($urandom_range(0, 2) != 0);
    if (rd_rsp_valid) begin
      rd_rsp_valid <= 1'b0;
    end else if (pend && dly == 0) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= $urandom;
    end else if (pend) begin
      dly = dly - 1;
    end
  end

  task automatic issue(logic [31:0] w, logic [63:0] a, logic [63:0] b, bit en, bit le);
    @(negedge clk);
    while (busy) @(negedge clk);
    insn = w; gpr_a = a; gpr_b = b; vec_en = en; little_end = le; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; gpr_a = '0; gpr_b = '0;
    vec_en = 1'b1; little_end = 1'b0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", 128'(busy), 0);
    chk("R11", "reset rd_req_valid", 128'(rd_req_valid), 0);
    chk("R11", "reset vwr_en", 128'(vwr_en), 0);
    chk("R11", "reset vec_unavail", 128'(vec_unavail), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    // R5 big-endian, each lane
    for (int k = 0; k < 4; k++) issue(mk_insn(3 + k, 4, 5), 64'h1000, 64'(4 * k), 1'b1, 1'b0);
    // R6 little-endian, each lane
    for (int k = 0; k < 4; k++) issue(mk_insn(20 + k, 4, 5), 64'h2000, 64'(4 * k), 1'b1, 1'b1);
    // R3 unaligned sum
    issue(mk_insn(7, 1, 2), 64'h3003, 64'h0006, 1'b1, 1'b0);
    // R2 zero first operand field, nonzero value ignored
    issue(mk_insn(8, 0, 2), 64'hDEAD_BEEF_0000_0000, 64'h44, 1'b1, 1'b1);
    // R2 wraparound
    issue(mk_insn(9, 3, 6), 64'hFFFF_FFFF_FFFF_FFFE, 64'h9, 1'b1, 1'b0);
    // R9 disabled vector facility
    issue(mk_insn(10, 3, 6), 64'h100, 64'h8, 1'b0, 1'b0);

    // R1 wrong opcodes ignored
    issue(mk_insn(11, 1, 1) ^ 32'h0400_0000, 64'h10, 64'h10, 1'b1, 1'b0);
    chk("R1", "busy after bad primary opcode", 128'(busy), 0);
    issue(mk_insn(11, 1, 1) ^ 32'h0000_0002, 64'h10, 64'h10, 1'b1, 1'b0);
    chk("R1", "busy after bad extended opcode", 128'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R1", "no request after bad opcode", 128'(rd_req_valid), 0);

    // R10 second instruction while busy is ignored
    @(negedge clk);
    insn = mk_insn(12, 1, 2); gpr_a = 64'h500; gpr_b = 64'h4; vec_en = 1'b1; little_end = 1'b0;
    insn_valid = 1'b1;
    @(negedge clk);
    insn = mk_insn(13, 1, 2); gpr_a = 64'h900; gpr_b = 64'h8;
    @(negedge clk);
    insn_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R10", "idle after one completion", 128'(busy), 0);

    // Mixed random traffic
    for (int n = 0; n < 60; n++) begin
      issue(mk_insn($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31)),
            {$urandom, $urandom}, {$urandom, $urandom},
            ($urandom_range(0, 5) != 0), $urandom_range(0, 1) == 1);
    end

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule